// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one I2C master transfer of one to four bytes to a 7-bit target whenever a host writes its control register with the go bit set. It does not toggle SCL or SDA. Instead it talks to a byte-level bus engine through a request/done handshake with four operations: start condition with address and direction, write one byte, read one byte, and stop condition. Each request is answered by a one-cycle done pulse that carries an ack/nack result and, for reads, the received byte.

Outgoing bytes come from a four-slot data buffer and incoming bytes are stored in that buffer. Slot i always belongs to byte i of the transfer. When the sequence ends, the block reports how many bytes completed, keeps a sticky error flag and a sticky abort flag, and can raise a level interrupt. A halt command ends a bus ownership that a chained transfer left open. While a sequence runs, the block shows busy and ignores further control writes.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write accepted while idle stores all bits except bit 0. Bit 0 (go) always reads back as 0.
- R2: With go set, bit 1 selects read (1) or write (0), bits 5:4 hold the byte count minus one, and every start request carries `target_addr`. Bus operation codes: 0 start, 1 write byte, 2 read byte, 3 stop.
- R3: A start is requested before a byte only when the bus is not already held. A nack on a start sets the error and abort flags and ends the sequence without a byte. An acked start clears the error flag.
- R4: A nack on a data byte sets the error and abort flags and ends the sequence at once, with no stop. The bus stays held.
- R5: After each acked byte a stop is requested when the repeated-start bit (bit 3) is set or the chain bit (bit 2) is clear. Otherwise the bus remains held with no stop.
- R6: When a sequence ends, `xfer_cnt` equals the number of bytes acked in it (0 to 4).
- R7: Byte i of a write is taken from buffer slot i. Byte i of a read is stored into slot i (bits 8i+7:8i of `buf_data`). Host loads go through `buf_wr`.
- R8: At the end of a sequence with at least one completed byte, `irq` rises only if `irq_en` and `mask_done` are both set.
- R9: A control write with bit 7 set while the bus is held and the block is idle requests only a stop, even if go is also set. It raises `irq` when `irq_en` and `mask_halt` are set, and leaves `xfer_cnt` unchanged.
- R10: While `busy` is high, control writes are ignored: no new sequence and no change to `ctrl_rdata`.
- R11: `irq_ack` clears `irq` and `abort_ack` clears the abort flag. Neither touches the error flag.
- R12: After reset, every output is 0 and all buffer slots hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (go, read, chain, restart, count, halt) |
| ctrl_rdata | output | 8 | Stored control value, bit 0 always 0 |
| target_addr | input | 7 | 7-bit target address |
| irq_en | input | 1 | Global interrupt enable |
| mask_done | input | 1 | Completion interrupt mask |
| mask_halt | input | 1 | Halt interrupt mask |
| irq_ack | input | 1 | Clears the interrupt |
| abort_ack | input | 1 | Clears the abort flag |
| buf_wr | input | 1 | Host write strobe into the data buffer |
| buf_widx | input | 2 | Buffer slot for the host write |
| buf_wdata | input | 8 | Host write byte |
| buf_data | output | 32 | All buffer slots, slot i at bits 8i+7:8i |
| bus_req | output | 1 | One-cycle bus operation request |
| bus_op | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| bus_addr | output | 7 | Target address for a start |
| bus_wdata | output | 8 | Byte for a write request, 0 otherwise |
| bus_done | input | 1 | One-cycle completion of the pending request |
| bus_nack | input | 1 | Nack result, valid with bus_done |
| bus_rdata | input | 8 | Received byte, valid with bus_done on a read |
| busy | output | 1 | Sequence or halt in progress |
| bus_held | output | 1 | The block owns the bus (start given, no stop yet) |
| err_flag | output | 1 | Error flag |
| abort_flag | output | 1 | Sticky transfer-abort flag |
| xfer_cnt | output | 3 | Bytes completed by the last sequence |
| irq | output | 1 | Level interrupt |

## Verification
A scripted bus responder answers every request after a short delay, and a scoreboard compares each request with a queue that the driver computes from the requirements. Write and read transfers of four and three bytes with a stop after every byte exercise the stop rule and the slot order. A chained transfer followed by a second chained one shows whether a held bus skips the start. Nacks placed on the first start and on the second data byte separate the partial count and the sticky flags from the error-clearing effect of a later good start. Halt writes with go also set, interrupt enables toggled, and a control write during a running sequence check halt precedence, interrupt gating and the busy lockout.

// File: rtl/i2cs_pkg.sv
// Shared types and control-field positions for the I2C master transfer sequencer.
// Assumes a fixed byte-wide data path and a power-of-two buffer depth.
package i2cs_pkg;
    localparam int DATA_W    = 8;
    localparam int BUF_DEPTH = 4;
    localparam int IDX_W     = $clog2(BUF_DEPTH);
    localparam int CNT_W     = $clog2(BUF_DEPTH + 1);
    localparam int ADDR_W    = 7;

    // Control field positions (decoded by the sequencer).
    localparam int CTL_GO      = 0;
    localparam int CTL_RD      = 1;
    localparam int CTL_CHAIN   = 2;
    localparam int CTL_RESTART = 3;
    localparam int CTL_CNT_LO  = 4;
    localparam int CTL_HALT    = 7;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic              rnw;
        logic              stop_each;
        logic [IDX_W-1:0]  cnt_m1;
        logic [ADDR_W-1:0] addr;
    } xfer_cfg_t;
endpackage

// File: rtl/i2cs_cmd_decode.sv
// Control register and command decode.
// Stores accepted control writes without the go bit, turns a write into a
// start or halt command, and captures the transfer configuration.
// Assumes the sequencer ignores commands while it reports busy.
module i2cs_cmd_decode
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_wdata,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic              seq_busy,
    input  logic              bus_held,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              start_go,
    output logic              halt_go,
    output xfer_cfg_t         cfg
);
    logic accept;

    // Purpose: a control write is only honoured while the sequencer is idle.
    always_comb accept = ctrl_wr && !seq_busy;

    // Purpose: a halt on a held bus wins over a start in the same write.
    always_comb begin
        halt_go  = accept && ctrl_wdata[CTL_HALT] && bus_held;
        start_go = accept && ctrl_wdata[CTL_GO] && !halt_go;
    end

    // Purpose: build the transfer configuration from the write data.
    always_comb begin
        cfg.rnw       = ctrl_wdata[CTL_RD];
        cfg.stop_each = ctrl_wdata[CTL_RESTART] | ~ctrl_wdata[CTL_CHAIN];
        cfg.cnt_m1    = ctrl_wdata[CTL_CNT_LO +: IDX_W];
        cfg.addr      = target_addr;
    end

    // Purpose: keep the readable control value, go bit never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= ctrl_wdata & ~(DATA_W'(1) << CTL_GO);
        end
    end
endmodule

// File: rtl/i2cs_data_buf.sv
// Data buffer of DEPTH byte slots.
// The host loads slots through its own port; the sequencer stores received
// bytes and takes the byte to send by index. On a collision in the same slot
// the sequencer's write wins.
module i2cs_data_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr,
    input  logic [IDX_W-1:0]        host_idx,
    input  logic [DATA_W-1:0]       host_data,
    input  logic                    seq_wr,
    input  logic [IDX_W-1:0]        seq_idx,
    input  logic [DATA_W-1:0]       seq_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [DATA_W-1:0]       rd_data,
    output logic [DEPTH*DATA_W-1:0] all_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Purpose: update one slot from the sequencer or the host.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (seq_wr && seq_idx == IDX_W'(g)) begin
                slot[g] <= seq_data;
            end else if (host_wr && host_idx == IDX_W'(g)) begin
                slot[g] <= host_data;
            end
        end
        assign all_data[g*DATA_W +: DATA_W] = slot[g];
    end

    // Purpose: present the byte the sequencer is about to send.
    always_comb rd_data = slot[rd_idx];
endmodule

// File: rtl/i2cs_seq_fsm.sv
// Transfer sequencer state machine.
// Issues start, byte and stop requests to the bus engine, one at a time,
// and waits for each done pulse. It tracks bus ownership and counts acked
// bytes. Assumes the bus engine answers every request with exactly one
// bus_done pulse, no earlier than the cycle after the request.
module i2cs_seq_fsm
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_go,
    input  logic              halt_go,
    input  xfer_cfg_t         cfg,
    input  logic              bus_done,
    input  logic              bus_nack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              rx_we,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              held,
    output logic              start_ok,
    output logic              xfer_err,
    output logic              fin,
    output logic [CNT_W-1:0]  fin_cnt,
    output logic              halt_done
);
    typedef enum logic [3:0] {
        S_IDLE, S_START, S_WSTART, S_BYTE, S_WBYTE, S_STOP, S_WSTOP,
        S_NEXT, S_FIN, S_HSTOP, S_WHSTOP
    } state_e;

    state_e           state;
    xfer_cfg_t        cfg_q;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] done_cnt;
    logic             last_byte;

    // Purpose: the current byte is the last one asked for.
    always_comb last_byte = (idx == cfg_q.cnt_m1);

    // Purpose: drive the request side of the bus handshake.
    always_comb begin
        bus_req   = 1'b0;
        bus_op    = OP_START;
        bus_wdata = '0;
        unique case (state)
            S_START: begin
                bus_req = 1'b1;
                bus_op  = OP_START;
            end
            S_BYTE: begin
                bus_req   = 1'b1;
                bus_op    = cfg_q.rnw ? OP_READ : OP_WRITE;
                bus_wdata = cfg_q.rnw ? '0 : tx_byte;
            end
            S_STOP, S_HSTOP: begin
                bus_req = 1'b1;
                bus_op  = OP_STOP;
            end
            default: ;
        endcase
    end

    // Purpose: event strobes toward the buffer and the status unit.
    always_comb begin
        bus_addr  = cfg_q.addr;
        buf_idx   = idx;
        rx_data   = bus_rdata;
        rx_we     = (state == S_WBYTE) && bus_done && !bus_nack && cfg_q.rnw;
        start_ok  = (state == S_WSTART) && bus_done && !bus_nack;
        xfer_err  = ((state == S_WSTART) || (state == S_WBYTE)) && bus_done && bus_nack;
        fin       = (state == S_FIN);
        fin_cnt   = done_cnt;
        halt_done = (state == S_WHSTOP) && bus_done;
        busy      = (state != S_IDLE);
    end

    // Purpose: step through start, byte and stop phases of a sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cfg_q    <= '0;
            idx      <= '0;
            done_cnt <= '0;
            held     <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (halt_go) begin
                        state <= S_HSTOP;
                    end else if (start_go) begin
                        cfg_q    <= cfg;
                        idx      <= '0;
                        done_cnt <= '0;
                        state    <= held ? S_BYTE : S_START;
                    end
                end
                S_START:  state <= S_WSTART;
                S_WSTART: begin
                    if (bus_done) begin
                        if (bus_nack) begin
                            state <= S_FIN;
                        end else begin
                            held  <= 1'b1;
                            state <= S_BYTE;
                        end
                    end
                end
                S_BYTE:   state <= S_WBYTE;
                S_WBYTE: begin
                    if (bus_done) begin
                        if (bus_nack) begin
                            state <= S_FIN;
                        end else begin
                            done_cnt <= done_cnt + CNT_W'(1);
                            state    <= cfg_q.stop_each ? S_STOP : S_NEXT;
                        end
                    end
                end
                S_STOP:   state <= S_WSTOP;
                S_WSTOP: begin
                    if (bus_done) begin
                        held  <= 1'b0;
                        state <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (last_byte) begin
                        state <= S_FIN;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= held ? S_BYTE : S_START;
                    end
                end
                S_FIN:    state <= S_IDLE;
                S_HSTOP:  state <= S_WHSTOP;
                S_WHSTOP: begin
                    if (bus_done) begin
                        held  <= 1'b0;
                        state <= S_IDLE;
                    end
                end
                default:  state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cs_status.sv
// Status flags, transfer count and interrupt.
// Error follows the last start or nack. Abort is sticky until acknowledged.
// The count is loaded when a sequence ends. The interrupt is a level held
// until acknowledged; a set in the same cycle wins over an acknowledge.
module i2cs_status
    import i2cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             xfer_err,
    input  logic             fin,
    input  logic [CNT_W-1:0] fin_cnt,
    input  logic             halt_done,
    input  logic             irq_en,
    input  logic             mask_done,
    input  logic             mask_halt,
    input  logic             irq_ack,
    input  logic             abort_ack,
    output logic             err_flag,
    output logic             abort_flag,
    output logic [CNT_W-1:0] xfer_cnt,
    output logic             irq
);
    logic irq_set;

    // Purpose: interrupt condition from completion or halt, both gated.
    always_comb irq_set = irq_en && ((fin && (fin_cnt != '0) && mask_done) ||
                                     (halt_done && mask_halt));

    // Purpose: error flag set by a nack, cleared by an acked start.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_flag <= 1'b0;
        else if (xfer_err) err_flag <= 1'b1;
        else if (start_ok) err_flag <= 1'b0;
    end

    // Purpose: sticky abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         abort_flag <= 1'b0;
        else if (xfer_err)  abort_flag <= 1'b1;
        else if (abort_ack) abort_flag <= 1'b0;
    end

    // Purpose: completed-byte count of the last sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)   xfer_cnt <= '0;
        else if (fin) xfer_cnt <= fin_cnt;
    end

    // Purpose: level interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end
endmodule

// File: rtl/i2c_xfer_seq.sv
// Top of the I2C master transfer sequencer.
// Joins the control decode, data buffer, sequencer and status unit.
// Assumes a byte-level bus engine with a request/done handshake.
module i2c_xfer_seq
    import i2cs_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctrl_wr,
    input  logic [DATA_W-1:0]           ctrl_wdata,
    output logic [DATA_W-1:0]           ctrl_rdata,
    input  logic [ADDR_W-1:0]           target_addr,
    input  logic                        irq_en,
    input  logic                        mask_done,
    input  logic                        mask_halt,
    input  logic                        irq_ack,
    input  logic                        abort_ack,
    input  logic                        buf_wr,
    input  logic [IDX_W-1:0]            buf_widx,
    input  logic [DATA_W-1:0]           buf_wdata,
    output logic [BUF_DEPTH*DATA_W-1:0] buf_data,
    output logic                        bus_req,
    output logic [1:0]                  bus_op,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_done,
    input  logic                        bus_nack,
    input  logic [DATA_W-1:0]           bus_rdata,
    output logic                        busy,
    output logic                        bus_held,
    output logic                        err_flag,
    output logic                        abort_flag,
    output logic [CNT_W-1:0]            xfer_cnt,
    output logic                        irq
);
    xfer_cfg_t         cfg;
    logic              start_go, halt_go;
    logic [IDX_W-1:0]  buf_idx;
    logic [DATA_W-1:0] tx_byte, rx_data;
    logic              rx_we, start_ok, xfer_err, fin, halt_done;
    logic [CNT_W-1:0]  fin_cnt;

    i2cs_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .target_addr(target_addr), .seq_busy(busy), .bus_held(bus_held),
        .ctrl_q(ctrl_rdata), .start_go(start_go), .halt_go(halt_go), .cfg(cfg)
    );

    i2cs_data_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .host_wr(buf_wr), .host_idx(buf_widx), .host_data(buf_wdata),
        .seq_wr(rx_we), .seq_idx(buf_idx), .seq_data(rx_data),
        .rd_idx(buf_idx), .rd_data(tx_byte), .all_data(buf_data)
    );

    i2cs_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_go(start_go), .halt_go(halt_go),
        .cfg(cfg), .bus_done(bus_done), .bus_nack(bus_nack),
        .bus_rdata(bus_rdata), .tx_byte(tx_byte), .bus_req(bus_req),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .buf_idx(buf_idx), .rx_we(rx_we), .rx_data(rx_data), .busy(busy),
        .held(bus_held), .start_ok(start_ok), .xfer_err(xfer_err),
        .fin(fin), .fin_cnt(fin_cnt), .halt_done(halt_done)
    );

    i2cs_status u_sts (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .xfer_err(xfer_err),
        .fin(fin), .fin_cnt(fin_cnt), .halt_done(halt_done),
        .irq_en(irq_en), .mask_done(mask_done), .mask_halt(mask_halt),
        .irq_ack(irq_ack), .abort_ack(abort_ack), .err_flag(err_flag),
        .abort_flag(abort_flag), .xfer_cnt(xfer_cnt), .irq(irq)
    );
endmodule

// File: rtl/i2cs_checker.sv
// Protocol checker for the transfer sequencer, bound to the top module.
// Remembers the last requested bus operation so that a nack can be
// matched to a start or a byte.
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic [DATA_W-1:0] ctrl_wdata,
    input logic [DATA_W-1:0] ctrl_rdata,
    input logic              irq_en,
    input logic              mask_done,
    input logic              mask_halt,
    input logic              bus_req,
    input logic [1:0]        bus_op,
    input logic              bus_done,
    input logic              bus_nack,
    input logic              busy,
    input logic              err_flag,
    input logic              abort_flag,
    input logic [CNT_W-1:0]  xfer_cnt,
    input logic              irq
);
    logic [1:0] last_op;

    // Purpose: remember the operation the pending done belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_op <= OP_STOP;
        else if (bus_req) last_op <= bus_op;
    end

    AST_CTRL_NO_GO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !busy) |=> (ctrl_rdata == ($past(ctrl_wdata) & 8'hFE))); // R1

    AST_NACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_done && bus_nack && last_op != OP_STOP) |=> (err_flag && abort_flag)); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cnt <= CNT_W'(BUF_DEPTH)); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(irq_en) && $past(mask_done || mask_halt))); // R8

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy); // R10

    AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && busy) |=> $stable(ctrl_rdata)); // R10
endmodule

bind i2c_xfer_seq i2cs_checker u_chk (.*);

// File: tb/test_i2c_xfer_seq.sv
// Scoreboard bench: driver tasks push the expected bus operations, and a
// monitor/responder compares every request and answers it.
module test_i2c_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic [6:0]  target_addr = 7'h52;
    logic        irq_en = 1'b0, mask_done = 1'b0, mask_halt = 1'b0;
    logic        irq_ack = 1'b0, abort_ack = 1'b0;
    logic        buf_wr = 1'b0;
    logic [1:0]  buf_widx = '0;
    logic [7:0]  buf_wdata = '0;
    logic [31:0] buf_data;
    logic        bus_req;
    logic [1:0]  bus_op;
    logic [6:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_done = 1'b0, bus_nack = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic        busy, bus_held, err_flag, abort_flag, irq;
    logic [2:0]  xfer_cnt;

    i2c_xfer_seq i_i2c_xfer_seq (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int rsp_k = 0, nack_at = -1;
    logic [16:0] exp_q[$];
    bit   held_m = 0, e_err = 0, e_abort = 0, e_irq = 0;
    int   e_cnt = 0;
    logic [7:0] e_buf[4] = '{default: 8'h00};
    bit   done_flag = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] item(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d);
        return {op, (op == 2'd0) ? a : 7'h0, (op == 2'd1) ? d : 8'h0};
    endfunction

    // Monitor and responder: compares each request, answers after two cycles.
    initial begin
        forever begin
            @(negedge clk);
            bus_done = 1'b0;
            bus_nack = 1'b0;
            if (bus_req) begin
                int kk;
                if (exp_q.size() == 0) begin
                    chk("R2/R5/R10 unexpected bus op", {15'h0, item(bus_op, bus_addr, bus_wdata)}, 32'h1ffff);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    chk("R2/R3/R5/R7 bus op", {15'h0, item(bus_op, bus_addr, bus_wdata)}, {15'h0, e});
                end
                kk = rsp_k;
                rsp_k++;
                repeat (2) @(negedge clk);
                bus_done  = 1'b1;
                bus_nack  = (kk == nack_at);
                bus_rdata = 8'hC0 + 8'(kk);
            end
        end
    end

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    // Driver: model the sequence from the requirements, then issue it.
    task automatic start_xfer(input logic [7:0] v, input int nk);
        bit rd = v[1];
        bit stop_each = v[3] | ~v[2];
        int n = int'(v[5:4]) + 1;
        int k = 0, done = 0;
        for (int i = 0; i < n; i++) begin
            if (!held_m) begin
                exp_q.push_back(item(2'd0, target_addr, 8'h0));
                if (k == nk) begin e_err = 1; e_abort = 1; break; end
                k++;
                e_err = 0;
                held_m = 1;
            end
            exp_q.push_back(item(rd ? 2'd2 : 2'd1, 7'h0, e_buf[i]));
            if (k == nk) begin e_err = 1; e_abort = 1; break; end
            if (rd) e_buf[i] = 8'hC0 + 8'(k);
            k++;
            done++;
            if (stop_each) begin
                exp_q.push_back(item(2'd3, 7'h0, 8'h0));
                k++;
                held_m = 0;
            end
        end
        e_cnt = done;
        if (done > 0 && irq_en && mask_done) e_irq = 1;
        rsp_k = 0;
        nack_at = nk;
        wr_ctrl(v);
        chk("R1 ctrl readback", {24'h0, ctrl_rdata}, {24'h0, v & 8'hFE});
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        chk({tag, " R6 count"}, {29'h0, xfer_cnt}, 32'(e_cnt));
        chk({tag, " R3/R4 err"}, {31'h0, err_flag}, {31'h0, e_err});
        chk({tag, " R4/R11 abort"}, {31'h0, abort_flag}, {31'h0, e_abort});
        chk({tag, " R8/R9 irq"}, {31'h0, irq}, {31'h0, e_irq});
        chk({tag, " R5 held"}, {31'h0, bus_held}, {31'h0, held_m});
        chk({tag, " R7 buffer"}, buf_data, {e_buf[3], e_buf[2], e_buf[1], e_buf[0]});
        chk({tag, " R2 ops drained"}, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic run(input string tag, input logic [7:0] v, input int nk);
        start_xfer(v, nk);
        wait_idle();
        check_state(tag);
    endtask

    task automatic halt(input string tag, input logic [7:0] v);
        exp_q.push_back(item(2'd3, 7'h0, 8'h0));
        held_m = 0;
        if (irq_en && mask_halt) e_irq = 1;
        rsp_k = 0;
        nack_at = -1;
        wr_ctrl(v);
        wait_idle();
        check_state(tag);
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        e_irq = 0;
        chk("R11 irq cleared", {31'h0, irq}, 32'd0);
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected idle");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset outputs", {busy, bus_held, err_flag, abort_flag, irq, xfer_cnt, bus_req, ctrl_rdata},
            32'h0);
        chk("R12 reset buffer", buf_data, 32'h0);

        for (int i = 0; i < 4; i++) begin
            buf_wr = 1'b1; buf_widx = 2'(i); buf_wdata = 8'h11 * 8'(i + 1);
            e_buf[i] = 8'h11 * 8'(i + 1);
            @(negedge clk);
        end
        buf_wr = 1'b0;
        chk("R7 host load", buf_data, 32'h44332211);

        irq_en = 1; mask_done = 1; mask_halt = 1;
        run("T1 write4 stop-each", 8'h31, -1);
        ack_irq();
        run("T2 read3 restart", 8'h2F, -1);
        ack_irq();
        target_addr = 7'h2B;
        run("T3 write2 chained", 8'h15, -1);
        ack_irq();
        run("T4 held bus no start", 8'h05, -1);
        ack_irq();
        mask_done = 0;
        halt("T5 halt over go", 8'h81);
        chk("R9 halt ctrl store", {24'h0, ctrl_rdata}, 32'h80);
        ack_irq();
        mask_done = 1;
        run("T6 start nack", 8'h11, 0);
        @(negedge clk); abort_ack = 1'b1;
        @(negedge clk); abort_ack = 1'b0;
        e_abort = 0;
        chk("R11 abort cleared", {31'h0, abort_flag}, 32'd0);
        chk("R11 err kept", {31'h0, err_flag}, 32'd1);
        run("T8 data nack", 8'h21, 4);
        ack_irq();
        @(negedge clk); abort_ack = 1'b1;
        @(negedge clk); abort_ack = 1'b0;
        e_abort = 0;
        irq_en = 0;
        halt("T9 halt no irq", 8'h80);
        run("T10 good start clears err", 8'h01, -1);
        irq_en = 1;
        start_xfer(8'h31, -1);
        repeat (3) @(negedge clk);
        wr_ctrl(8'h03);
        chk("R10 write ignored while busy", {24'h0, ctrl_rdata}, 32'h30);
        wait_idle();
        check_state("T11 busy lockout");
        summary();
    end
endmodule